// File: doc/BRIEF.md
# Join Request Frame Parser

The parser takes raw Ethernet frames from one network port as a stream of 64 bits per clock. It has no ready signal, so it never stalls the stream. Each frame carries a hash-join header after the Ethernet addresses. The header holds a relation number, a sequence number, a tuple count and a flag that marks the frame as a build (hash) request or a probe request. After the header comes a body of fixed 32-byte tuples. Every complete tuple is copied into an internal queue of `DEPTH` entries. Each entry is tagged with the request kind and the relation number. A downstream hash unit drains the queue through a valid/ready pair.

When the header is complete, the parser checks the declared tuple count against the free queue entries. If the frame does not fit, it is thrown away whole. Its sequence number and relation number then go out on a one-cycle re-request strobe, so the sender can transmit that data again. Frames of a foreign EtherType are skipped without any report. A frame that stops short of the data it declared raises a malformed strobe. Nothing is remembered from one frame to the next.

Top module: `join_frame_parser`

## Requirements
- R1: Bit 63 of the first beat is the first bit on the wire, and the header takes exactly four beats. In beat 1, bits [31:16] hold the EtherType, [15:8] the relation number and [7:0] the key id. In beat 2, bits [63:32] hold the sequence number and [31:0] the tuple count. In beat 3, bits [63:56] hold the request flag and the remaining bits are padding. Any beat may arrive with `s_valid` low in between, and such cycles are ignored.
- R2: In an accepted frame, each tuple is four beats. Its first beat lands in `m_tuple[255:192]` and its last beat in `m_tuple[63:0]`. It comes out with `m_hash` = 1 if the flag byte is nonzero (0 means probe) and with `m_rel` equal to the frame's relation number. Tuples come out in arrival order.
- R3: The queue presents its oldest entry while `m_valid` is high, keeps it stable until `m_valid && m_ready`, never overflows, and `m_valid` is low only when the queue is empty.
- R4: A frame whose tuple count exceeds the free entries at the header's last beat is dropped whole and enqueues nothing. A count equal to the free entries is accepted.
- R5: A dropped frame raises `rr_valid` for exactly one cycle, in the cycle after its header's last beat, with `rr_seq` and `rr_rel` set to its sequence and relation numbers.
- R6: A frame whose EtherType differs from `JOIN_ETYPE` enqueues nothing and raises neither `rr_valid` nor `bad_frame`.
- R7: A matching frame that ends (`s_last`) inside its header, or before its declared tuples are complete, pulses `bad_frame` for one cycle in the cycle after the last beat. Tuples already completed stay in the queue, and a trailing partial tuple is discarded.
- R8: Beats after the declared tuples, up to `s_last`, are consumed and ignored. A tuple count of zero enqueues nothing and is not malformed.
- R9: The beat after `s_last` is always taken as beat 0 of a new header, even back to back with no idle cycle.
- R10: During and right after reset, `m_valid`, `rr_valid` and `bad_frame` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 64 | Frame beat, first wire byte in [63:56] |
| s_valid | input | 1 | Beat present |
| s_last | input | 1 | Final beat of the frame |
| m_valid | output | 1 | Queue head holds a tuple |
| m_ready | input | 1 | Consumer takes the head tuple |
| m_tuple | output | 256 | Eight 32-bit tuple words, first word in [255:224] |
| m_hash | output | 1 | 1 = build request, 0 = probe request |
| m_rel | output | 8 | Relation number of the tuple |
| rr_valid | output | 1 | One-cycle strobe for a dropped frame |
| rr_seq | output | 32 | Sequence number of the dropped frame |
| rr_rel | output | 8 | Relation number of the dropped frame |
| bad_frame | output | 1 | One-cycle strobe for a short frame |

## Verification
A tuple shows at the queue head in the cycle after the clock edge that took its fourth beat, provided it is alone in the queue. `rr_valid` and `bad_frame` are due one cycle after the beat that decides them. These decisions come at the header's last beat and at `s_last`. The bench keeps its own copy of the queue and applies each edge's pop and push in the same step that drives that edge's inputs. It then compares every output at the following falling edge, so each result is checked in exactly the cycle it is due. The drop decision in the bench reads its own queue occupancy just before the deciding edge, which is the value the design sees at that edge.

// File: rtl/join_frame_parser.sv
module join_frame_parser #(
  parameter int          DEPTH      = 8,
  parameter logic [15:0] JOIN_ETYPE = 16'h88B5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [63:0]  s_data,
  input  logic         s_valid,
  input  logic         s_last,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [255:0] m_tuple,
  output logic         m_hash,
  output logic [7:0]   m_rel,
  output logic         rr_valid,
  output logic [31:0]  rr_seq,
  output logic [7:0]   rr_rel,
  output logic         bad_frame
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);
  localparam int EW = 256 + 1 + 8;

  typedef enum logic [1:0] {ST_HDR, ST_BODY, ST_SKIP} st_t;

  st_t            st;
  logic [1:0]     hbeat;
  logic [1:0]     wcnt;
  logic [31:0]    remain;
  logic [31:0]    seq_q;
  logic [31:0]    cnt_q;
  logic [7:0]     rel_q;
  logic           hash_q;
  logic [191:0]   tbuf;

  logic [EW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [OW-1:0]  occ;

  logic           etype_ok;
  logic [31:0]    free_w;
  logic           wr_en, rd_en;

  assign etype_ok = s_data[31:16] == JOIN_ETYPE;
  assign free_w   = 32'(DEPTH) - 32'(occ);
  assign wr_en    = s_valid && st == ST_BODY && wcnt == 2'd3;
  assign rd_en    = m_valid && m_ready;
  assign m_valid  = occ != '0;
  assign {m_hash, m_rel, m_tuple} = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= {hash_q, rel_q, tbuf, s_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_HDR;
      hbeat     <= '0;
      wcnt      <= '0;
      remain    <= '0;
      seq_q     <= '0;
      cnt_q     <= '0;
      rel_q     <= '0;
      hash_q    <= 1'b0;
      tbuf      <= '0;
      rr_valid  <= 1'b0;
      rr_seq    <= '0;
      rr_rel    <= '0;
      bad_frame <= 1'b0;
    end else begin
      rr_valid  <= 1'b0;
      bad_frame <= 1'b0;
      if (s_valid) begin
        case (st)
          ST_HDR: begin
            hbeat <= hbeat + 1'b1;
            case (hbeat)
              2'd0: if (s_last) bad_frame <= 1'b1;
              2'd1: begin
                rel_q <= s_data[15:8];
                if (!etype_ok) begin
                  if (!s_last) st <= ST_SKIP;
                end else if (s_last) begin
                  bad_frame <= 1'b1;
                end
              end
              2'd2: begin
                seq_q <= s_data[63:32];
                cnt_q <= s_data[31:0];
                if (s_last) bad_frame <= 1'b1;
              end
              default: begin
                hash_q <= s_data[63:56] != 8'd0;
                if (cnt_q > free_w) begin
                  rr_valid <= 1'b1;
                  rr_seq   <= seq_q;
                  rr_rel   <= rel_q;
                  if (!s_last) st <= ST_SKIP;
                end else if (cnt_q == 32'd0) begin
                  if (!s_last) st <= ST_SKIP;
                end else if (s_last) begin
                  bad_frame <= 1'b1;
                end else begin
                  st     <= ST_BODY;
                  remain <= cnt_q;
                  wcnt   <= '0;
                end
              end
            endcase
            if (s_last) hbeat <= '0;
          end
          ST_BODY: begin
            wcnt <= wcnt + 1'b1;
            tbuf <= {tbuf[127:0], s_data};
            if (wcnt == 2'd3) remain <= remain - 1'b1;
            if (s_last) begin
              st    <= ST_HDR;
              hbeat <= '0;
              if (!(wcnt == 2'd3 && remain == 32'd1)) bad_frame <= 1'b1;
            end else if (wcnt == 2'd3 && remain == 32'd1) begin
              st <= ST_SKIP;
            end
          end
          default: begin
            if (s_last) begin
              st    <= ST_HDR;
              hbeat <= '0;
            end
          end
        endcase
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> occ < OW'(DEPTH)); // R3
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH)); // R3
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_tuple) && $stable(m_rel))); // R3
  AST_RR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rr_valid |=> !rr_valid); // R5
  AST_DROP_NOT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rr_valid && bad_frame)); // R7
  AST_BAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_frame |=> !bad_frame); // R7

endmodule

// File: tb/test_join_frame_parser.sv
`timescale 1ns/1ps
module test_join_frame_parser;
  localparam int          DEPTH = 8;
  localparam logic [15:0] JT    = 16'h88B5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n = 1'b0;
  logic [63:0]  s_data = '0;
  logic         s_valid = 1'b0, s_last = 1'b0, m_ready = 1'b0;
  logic         m_valid, m_hash, rr_valid, bad_frame;
  logic [255:0] m_tuple;
  logic [7:0]   m_rel, rr_rel;
  logic [31:0]  rr_seq;

  join_frame_parser #(.DEPTH(DEPTH), .JOIN_ETYPE(JT)) i_join_frame_parser (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_tuple(m_tuple), .m_hash(m_hash),
    .m_rel(m_rel), .rr_valid(rr_valid), .rr_seq(rr_seq), .rr_rel(rr_rel),
    .bad_frame(bad_frame));

  int checks = 0, failures = 0;
  int rmode = 0;
  logic [264:0] mq[$];
  logic exp_rr = 1'b0, exp_bad = 1'b0;
  logic [31:0] exp_seq = '0;
  logic [7:0]  exp_rel = '0;

  task automatic chk(input bit ok, input string what, input logic [264:0] act, input logic [264:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input logic [63:0] d, input bit l, input bit push,
                     input logic [264:0] ent, input bit nrr, input bit nbad, input string ctx);
    @(negedge clk);
    chk(m_valid == (mq.size() != 0), {"R3 m_valid ", ctx}, 265'(m_valid), 265'(mq.size() != 0));
    if (mq.size() != 0 && m_valid)
      chk({m_hash, m_rel, m_tuple} == mq[0], {"R2 head ", ctx}, {m_hash, m_rel, m_tuple}, mq[0]);
    chk(rr_valid == exp_rr, {"R5 rr_valid ", ctx}, 265'(rr_valid), 265'(exp_rr));
    if (exp_rr && rr_valid)
      chk({rr_seq, rr_rel} == {exp_seq, exp_rel}, {"R5 fields ", ctx},
          265'({rr_seq, rr_rel}), 265'({exp_seq, exp_rel}));
    chk(bad_frame == exp_bad, {"R7 bad_frame ", ctx}, 265'(bad_frame), 265'(exp_bad));
    s_valid = v; s_data = d; s_last = l;
    m_ready = (rmode == 0) ? ($urandom % 4 != 0) : (rmode == 2);
    if (m_ready && mq.size() != 0) void'(mq.pop_front());
    if (push) mq.push_back(ent);
    exp_rr = nrr; exp_bad = nbad;
  endtask

  task automatic send_frame(input logic [15:0] et, input logic [7:0] rel, input logic [31:0] seq,
                            input int cnt, input logic [7:0] flag, input int nb, input int gap,
                            input string ctx);
    logic [255:0] tb = '0;
    bit ok = (et == JT);
    bit acc = 1'b0;
    for (int b = 0; b < nb; b++) begin
      logic [63:0]  d;
      bit           l = (b == nb - 1);
      bit           push = 0, nrr = 0, nbad = 0;
      logic [264:0] ent = '0;
      while (gap != 0 && ($urandom % 100) < gap) cyc(0, '0, 0, 0, '0, 0, 0, ctx);
      case (b)
        0: d = {32'($urandom), 32'($urandom)};
        1: d = {32'($urandom), et, rel, 8'($urandom)};
        2: d = {seq, 32'(cnt)};
        3: d = {flag, 24'($urandom), 32'($urandom)};
        default: d = {32'($urandom), 32'($urandom)};
      endcase
      if (b == 0 && l) nbad = 1;
      if ((b == 1 || b == 2) && l && ok) nbad = 1;
      if (b == 3 && ok) begin
        if (cnt > DEPTH - mq.size()) begin
          nrr = 1; exp_seq = seq; exp_rel = rel;
        end else if (cnt > 0) begin
          acc = 1;
          if (l) nbad = 1;
        end
      end
      if (b >= 4 && acc) begin
        int k = b - 4;
        int t = k / 4;
        int w = k % 4;
        int done;
        if (t < cnt) begin
          tb = {tb[191:0], d};
          if (w == 3) begin push = 1; ent = {flag != 8'd0, rel, tb}; end
        end
        done = (w == 3) ? t + 1 : t;
        if (l && done < cnt) nbad = 1;
      end
      cyc(1, d, l, push, ent, nrr, nbad, ctx);
    end
  endtask

  task automatic drain(input string ctx);
    rmode = 2;
    for (int i = 0; i < DEPTH + 3; i++) cyc(0, '0, 0, 0, '0, 0, 0, ctx);
    rmode = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!m_valid && !rr_valid && !bad_frame, "R10 state during reset", 265'({m_valid, rr_valid, bad_frame}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!m_valid && !rr_valid && !bad_frame, "R10 state after reset", 265'({m_valid, rr_valid, bad_frame}), '0);

    rmode = 1;
    send_frame(JT, 8'h11, 32'hA000_0001, DEPTH, 8'h01, 4 + 4 * DEPTH, 0, "R4 exact fit R1");
    send_frame(JT, 8'h22, 32'hA000_0002, 1, 8'h00, 8, 0, "R4 drop when full");
    send_frame(JT, 8'h23, 32'hA000_0003, 0, 8'h00, 4, 0, "R8 zero count full queue");
    drain("R3 drain");
    send_frame(16'h0800, 8'h33, 32'hB0, 2, 8'h01, 12, 0, "R6 foreign etype");
    send_frame(JT, 8'h44, 32'hC0, 3, 8'h00, 10, 10, "R7 truncated body");
    send_frame(JT, 8'h45, 32'hC1, 2, 8'h01, 3, 0, "R7 truncated header");
    send_frame(JT, 8'h55, 32'hD0, 1, 8'h07, 13, 0, "R8 trailing beats");
    send_frame(JT, 8'h56, 32'hD1, 0, 8'h00, 9, 0, "R8 zero count");
    send_frame(JT, 8'h66, 32'hE0, 1, 8'h01, 8, 0, "R9 back to back a");
    send_frame(JT, 8'h67, 32'hE1, 1, 8'h00, 8, 0, "R9 back to back b");
    drain("R3 drain");

    for (int f = 0; f < 400; f++) begin
      int cnt  = $urandom % (DEPTH + 3);
      int base = 4 + 4 * cnt;
      int r    = $urandom % 8;
      int nb   = (r == 0) ? 1 + $urandom % base : (r == 1) ? base + 1 + $urandom % 5 : base;
      logic [15:0] et = ($urandom % 8 == 0) ? 16'($urandom) : JT;
      rmode = ($urandom % 5 == 0) ? 1 : 0;
      send_frame(et, 8'($urandom), 32'($urandom), cnt, ($urandom % 2) ? 8'($urandom) : 8'd0,
                 nb, ($urandom % 2) ? 20 : 0, "R2 random");
    end
    drain("R3 final drain");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule